// File: doc/BRIEF.md
# MII Management Serial Master

This block runs a single register transaction, read or write, between a station and a PHY over the two-wire management interface. A one-cycle `start_i` pulse latches the request: direction, a 5-bit PHY address, a 5-bit register number and, for writes, 16 bits of data. The block then produces the whole serial frame. It drives the management clock, the serial data output and a per-bit output enable for an external tristate buffer. On reads it samples the serial data input.

A frame has 65 bit periods, indexed k = 0..64. Each bit period is a low phase of `DIV` system clocks followed by a high phase of `DIV` system clocks, so a frame takes 130·`DIV` system clocks. `busy_o` covers the frame. After the frame, `done_o` pulses for one cycle. For a read, the captured word appears on `rd_data_o` in that same cycle.

Top module: `mii_mgmt_master`

## Requirements
- R1: While reset is held and in the first cycle after it, `mdc_o`, `mdo_o`, `mdo_en_o`, `busy_o` and `done_o` are 0 and `rd_data_o` is 0.
- R2: Bits k=0..31 are ones. k=32,33 carry 0 then 1. k=34,35 carry 1,0 for a read and 0,1 for a write. k=36..40 carry the PHY address MSB first and k=41..45 the register number MSB first. `mdo_en_o` is 1 for all of k=0..45.
- R3: A start accepted at a clock edge puts bit 0 on the pins in the following cycle. Every bit keeps `mdc_o` low for `DIV` cycles, then high for `DIV` cycles. `mdo_o` and `mdo_en_o` change only when a new bit's low phase begins.
- R4: In a write, k=46,47 have `mdo_en_o`=0 and `mdo_o`=0. k=48..63 then carry the 16 write data bits, MSB first, with `mdo_en_o`=1.
- R5: In a read, `mdo_en_o` and `mdo_o` are 0 from k=46 to the end of the frame. `mdi_i` is sampled in the last system clock of the high phase of k=48..63, and the first sample becomes the MSB. `mdi_i` has no effect at any other time.
- R6: Bit k=64 is a closing clock: `mdc_o` pulses as in R3 while `mdo_o` and `mdo_en_o` are 0.
- R7: `busy_o` is 1 for exactly 130·`DIV` cycles, starting the cycle after the accepted start. A `start_i` pulse while `busy_o` is 1 is ignored. Changes to the request inputs after the start do not alter the frame.
- R8: `done_o` is 1 for exactly the one cycle after `busy_o` falls. In that cycle a read frame's captured word appears on `rd_data_o`. A write frame leaves `rd_data_o` unchanged, and `rd_data_o` changes in no other cycle.
- R9: Whenever `busy_o` is 0, `mdc_o`, `mdo_o` and `mdo_en_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse; accepted only when idle |
| rd_not_wr_i | input | 1 | 1 selects read, 0 selects write |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register number |
| wr_data_i | input | 16 | Data for a write frame |
| mdi_i | input | 1 | Serial data from the PHY |
| mdc_o | output | 1 | Management clock |
| mdo_o | output | 1 | Serial data toward the PHY |
| mdo_en_o | output | 1 | Enable for the external data driver |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| rd_data_o | output | 16 | Word captured by the last read |

## Verification
Most internal state is visible on the pins. A wrong phase counter or bit index shifts the pin pattern in the first bit period it touches. A fault in the segment decoding shows up as a wrong `mdo_o` or `mdo_en_o` value at a specific bit index. The bench therefore compares every system clock of every frame against a waveform built from the requirements.

Capture faults stay hidden until the frame closes, when they appear as a wrong `rd_data_o`. To expose sampling in the wrong phase, the bench drives `mdi_i` with random values outside the sampling window. A wrong frame length shows up as a mis-timed `busy_o` or `done_o` edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    // field widths of one management frame
    localparam int PHY_AW  = 5;
    localparam int REG_AW  = 5;
    localparam int DATA_W  = 16;
    localparam int PRE_LEN = 32;

    // bit positions of each frame segment
    localparam int SOF_POS  = PRE_LEN;
    localparam int OP_POS   = SOF_POS + 2;
    localparam int PA_POS   = OP_POS + 2;
    localparam int RA_POS   = PA_POS + PHY_AW;
    localparam int TA_POS   = RA_POS + REG_AW;
    localparam int DAT_POS  = TA_POS + 2;
    localparam int END_POS  = DAT_POS + DATA_W;
    localparam int NUM_BITS = END_POS + 1;
    localparam int IDX_W    = $clog2(NUM_BITS);

    typedef logic [IDX_W-1:0] bit_idx_t;

    typedef enum logic [2:0] {
        SEG_PRE,
        SEG_SOF,
        SEG_OP,
        SEG_PA,
        SEG_RA,
        SEG_TA,
        SEG_DAT,
        SEG_END
    } seg_e;

    typedef struct packed {
        logic              rd;
        logic [PHY_AW-1:0] pa;
        logic [REG_AW-1:0] ra;
        logic [DATA_W-1:0] wd;
    } mdio_req_t;

    typedef struct packed {
        logic d;
        logic oe;
    } pin_drv_t;

    function automatic seg_e seg_of(input bit_idx_t idx);
        int k;
        k = int'(idx);
        if (k < SOF_POS)      return SEG_PRE;
        else if (k < OP_POS)  return SEG_SOF;
        else if (k < PA_POS)  return SEG_OP;
        else if (k < RA_POS)  return SEG_PA;
        else if (k < TA_POS)  return SEG_RA;
        else if (k < DAT_POS) return SEG_TA;
        else if (k < END_POS) return SEG_DAT;
        else                  return SEG_END;
    endfunction

endpackage

// File: rtl/mdio_bit_timer.sv
module mdio_bit_timer
    import mdio_pkg::*;
#(
    parameter int DIV = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     go,
    output logic     busy_o,
    output logic     hi_o,
    output logic     smp_o,
    output logic     end_o,
    output logic     done_o,
    output bit_idx_t idx_o
);

    localparam int              CNT_W    = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV - 1);
    localparam bit_idx_t        IDX_LAST = bit_idx_t'(END_POS);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             hi_q;
    logic             done_q;
    bit_idx_t         idx_q;
    logic             ph_end;

    assign ph_end = busy_q && (cnt_q == CNT_LAST);
    assign smp_o  = ph_end && hi_q;
    assign end_o  = smp_o && (idx_q == IDX_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            hi_q   <= 1'b0;
            done_q <= 1'b0;
            idx_q  <= '0;
        end else begin
            done_q <= end_o;
            if (go) begin
                busy_q <= 1'b1;
                hi_q   <= 1'b0;
                cnt_q  <= '0;
                idx_q  <= '0;
            end else if (busy_q) begin
                if (ph_end) begin
                    cnt_q <= '0;
                    hi_q  <= ~hi_q;
                    if (hi_q) begin
                        if (idx_q == IDX_LAST) busy_q <= 1'b0;
                        else                   idx_q  <= idx_q + 1'b1;
                    end
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign busy_o = busy_q;
    assign hi_o   = hi_q;
    assign done_o = done_q;
    assign idx_o  = idx_q;

    AST_GO_IDLE_ONLY: assert property (@(posedge clk) disable iff (rst)
        go |-> !busy_q); // R7
    AST_BIT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q) && $fell(hi_q)) |-> (idx_q == $past(idx_q) + 1'b1)); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R8

endmodule

// File: rtl/mdio_tx_pattern.sv
module mdio_tx_pattern
    import mdio_pkg::*;
(
    input  mdio_req_t req,
    input  bit_idx_t  idx,
    input  logic      busy,
    output pin_drv_t  drv
);

    int                k;
    logic [PHY_AW-1:0] pa_sh;
    logic [REG_AW-1:0] ra_sh;
    logic [DATA_W-1:0] wd_sh;

    always_comb begin
        k     = int'(idx);
        pa_sh = '0;
        ra_sh = '0;
        wd_sh = '0;
        drv   = '{d: 1'b0, oe: 1'b0};
        if (busy) begin
            unique case (seg_of(idx))
                SEG_PRE: drv = '{d: 1'b1, oe: 1'b1};
                SEG_SOF: drv = '{d: (k == SOF_POS + 1), oe: 1'b1};
                SEG_OP:  drv = '{d: (req.rd ? (k == OP_POS) : (k == OP_POS + 1)), oe: 1'b1};
                SEG_PA: begin
                    pa_sh = req.pa << (k - PA_POS);
                    drv   = '{d: pa_sh[PHY_AW-1], oe: 1'b1};
                end
                SEG_RA: begin
                    ra_sh = req.ra << (k - RA_POS);
                    drv   = '{d: ra_sh[REG_AW-1], oe: 1'b1};
                end
                SEG_TA:  drv = '{d: 1'b0, oe: 1'b0};
                SEG_DAT: begin
                    wd_sh = req.wd << (k - DAT_POS);
                    drv   = '{d: (!req.rd && wd_sh[DATA_W-1]), oe: !req.rd};
                end
                SEG_END: drv = '{d: 1'b0, oe: 1'b0};
                default: drv = '{d: 1'b0, oe: 1'b0};
            endcase
        end
    end

endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              rd,
    input  logic              smp,
    input  logic              frame_end,
    input  bit_idx_t          idx,
    input  logic              mdi,
    output logic [DATA_W-1:0] rd_data_o
);

    logic [DATA_W-1:0] sh_q;
    logic [DATA_W-1:0] rd_q;
    logic              in_data;

    assign in_data = (int'(idx) >= DAT_POS) && (int'(idx) < END_POS);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
            rd_q <= '0;
        end else begin
            if (go)
                sh_q <= '0;
            else if (smp && rd && in_data)
                sh_q <= {sh_q[DATA_W-2:0], mdi};
            if (frame_end && rd)
                rd_q <= sh_q;
        end
    end

    assign rd_data_o = rd_q;

    AST_SHIFT_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
        (!rd && !go) |=> $stable(sh_q)); // R5

endmodule

// File: rtl/mii_mgmt_master.sv
module mii_mgmt_master
    import mdio_pkg::*;
#(
    parameter int DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              rd_not_wr_i,
    input  logic [PHY_AW-1:0] phy_addr_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              mdi_i,
    output logic              mdc_o,
    output logic              mdo_o,
    output logic              mdo_en_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rd_data_o
);

    mdio_req_t req_q;
    logic      go;
    logic      busy;
    logic      hi;
    logic      smp;
    logic      fend;
    logic      done;
    bit_idx_t  idx;
    pin_drv_t  drv;

    // a request is taken only between frames
    assign go = start_i && !busy;

    always_ff @(posedge clk) begin
        if (rst)
            req_q <= '0;
        else if (go)
            req_q <= '{rd: rd_not_wr_i, pa: phy_addr_i, ra: reg_addr_i, wd: wr_data_i};
    end

    mdio_bit_timer #(.DIV(DIV)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .go     (go),
        .busy_o (busy),
        .hi_o   (hi),
        .smp_o  (smp),
        .end_o  (fend),
        .done_o (done),
        .idx_o  (idx)
    );

    mdio_tx_pattern u_tx (
        .req  (req_q),
        .idx  (idx),
        .busy (busy),
        .drv  (drv)
    );

    mdio_rx_shift u_rx (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .rd        (req_q.rd),
        .smp       (smp),
        .frame_end (fend),
        .idx       (idx),
        .mdi       (mdi_i),
        .rd_data_o (rd_data_o)
    );

    assign mdc_o    = busy && hi;
    assign mdo_o    = drv.d;
    assign mdo_en_o = drv.oe;
    assign busy_o   = busy;
    assign done_o   = done;

    AST_IDLE_PINS: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!mdc_o && !mdo_o && !mdo_en_o)); // R9
    AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (rst)
        mdc_o |-> ($stable(mdo_o) && $stable(mdo_en_o))); // R3
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(rd_data_o)); // R8
    AST_DONE_AFTER_FRAME: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o))); // R8
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> $stable(req_q)); // R7
    AST_READ_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (busy_o && req_q.rd && (int'(idx) >= TA_POS)) |-> !mdo_en_o); // R5

endmodule

// File: tb/mii_mgmt_master_tb.sv
module mii_mgmt_master_tb;

    localparam int DIV       = 3;
    localparam int NB        = 65;
    localparam int FRAME_CYC = NB * 2 * DIV;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic        rd_not_wr_i;
    logic [4:0]  phy_addr_i;
    logic [4:0]  reg_addr_i;
    logic [15:0] wr_data_i;
    logic        mdi_i;
    logic        mdc_o, mdo_o, mdo_en_o, busy_o, done_o;
    logic [15:0] rd_data_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [15:0] last_rd = 16'h0000;

    always #2 clk = ~clk;

    mii_mgmt_master #(.DIV(DIV)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .rd_not_wr_i (rd_not_wr_i),
        .phy_addr_i  (phy_addr_i),
        .reg_addr_i  (reg_addr_i),
        .wr_data_i   (wr_data_i),
        .mdi_i       (mdi_i),
        .mdc_o       (mdc_o),
        .mdo_o       (mdo_o),
        .mdo_en_o    (mdo_en_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .rd_data_o   (rd_data_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // expected serial data and enable, k=0 at the MSB end
    function automatic logic [NB-1:0] exp_data(input bit rd, input logic [4:0] pa,
                                               input logic [4:0] ra, input logic [15:0] wd);
        if (rd) return {32'hFFFF_FFFF, 2'b01, 2'b10, pa, ra, 19'b0};
        else    return {32'hFFFF_FFFF, 2'b01, 2'b01, pa, ra, 2'b00, wd, 1'b0};
    endfunction

    function automatic logic [NB-1:0] exp_oe(input bit rd);
        if (rd) return {{46{1'b1}}, 19'b0};
        else    return {{46{1'b1}}, 2'b00, {16{1'b1}}, 1'b0};
    endfunction

    task automatic run_frame(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                             input logic [15:0] wd, input logic [15:0] phy_val,
                             input bit poke, input string tag);
        logic [NB-1:0] ed, eo;
        bit wave_ok;
        int bad_t;
        logic [3:0] act_v, exp_v;
        ed = exp_data(rd, pa, ra, wd);
        eo = exp_oe(rd);
        wave_ok = 1'b1;
        bad_t = 0;
        act_v = '0;
        exp_v = '0;
        rd_not_wr_i = rd;
        phy_addr_i  = pa;
        reg_addr_i  = ra;
        wr_data_i   = wd;
        start_i     = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        // scramble the request inputs once the frame has started (R7)
        rd_not_wr_i = ~rd;
        phy_addr_i  = ~pa;
        reg_addr_i  = ~ra;
        wr_data_i   = ~wd;
        for (int t = 0; t < FRAME_CYC; t++) begin
            int  k;
            bit  hi;
            logic [3:0] a, e;
            k  = t / (2 * DIV);
            hi = ((t / DIV) % 2) == 1;
            a  = {busy_o, mdc_o, mdo_o, mdo_en_o};
            e  = {1'b1, hi, ed[NB-1-k], eo[NB-1-k]};
            if (wave_ok && a !== e) begin
                wave_ok = 1'b0;
                bad_t = t;
                act_v = a;
                exp_v = e;
            end
            if (rd && hi && k >= 48 && k <= 63)
                mdi_i = phy_val[63 - k];
            else
                mdi_i = 1'($urandom);
            start_i = (poke && t == FRAME_CYC / 2);
            if (poke && t == FRAME_CYC / 2) rd_not_wr_i = 1'($urandom);
            @(posedge clk);
            @(negedge clk);
        end
        start_i = 1'b0;
        // R2 R3 R4 R5 R6 R7: whole-frame waveform {busy,mdc,mdo,oe}
        check(wave_ok, "R2/R3/R4/R5/R6/R7", $sformatf("%s waveform at cycle %0d", tag, bad_t),
              32'(act_v), 32'(exp_v));
        // R8: done pulse right after busy falls
        check(done_o === 1'b1 && busy_o === 1'b0, "R8", {tag, " done/busy at frame end"},
              {30'b0, done_o, busy_o}, 32'h2);
        if (rd) last_rd = phy_val;
        check(rd_data_o === last_rd, "R8", {tag, " rd_data at done"},
              32'(rd_data_o), 32'(last_rd));
        @(posedge clk);
        @(negedge clk);
        // R8 R9: single-cycle done, pins idle
        check(done_o === 1'b0 && {mdc_o, mdo_o, mdo_en_o, busy_o} === 4'b0, "R9",
              {tag, " idle after done"}, {27'b0, done_o, mdc_o, mdo_o, mdo_en_o, busy_o}, 32'h0);
        check(rd_data_o === last_rd, "R8", {tag, " rd_data held"},
              32'(rd_data_o), 32'(last_rd));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        rst = 1'b1;
        start_i = 1'b0;
        rd_not_wr_i = 1'b0;
        phy_addr_i = '0;
        reg_addr_i = '0;
        wr_data_i = '0;
        mdi_i = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check({mdc_o, mdo_o, mdo_en_o, busy_o, done_o} === 5'b0 && rd_data_o === 16'h0,
              "R1", "outputs in reset", {11'b0, mdc_o, mdo_o, mdo_en_o, busy_o, done_o, rd_data_o}, 32'h0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check({mdc_o, mdo_o, mdo_en_o, busy_o, done_o} === 5'b0 && rd_data_o === 16'h0,
              "R1", "outputs after reset", {11'b0, mdc_o, mdo_o, mdo_en_o, busy_o, done_o, rd_data_o}, 32'h0);
        // R9: idle pins ignore mdi toggling
        for (int i = 0; i < 5; i++) begin
            mdi_i = 1'($urandom);
            @(posedge clk);
            @(negedge clk);
        end
        check({mdc_o, mdo_o, mdo_en_o} === 3'b0, "R9", "idle pins with mdi toggling",
              {29'b0, mdc_o, mdo_o, mdo_en_o}, 32'h0);

        // directed corners
        run_frame(1'b1, 5'd0,  5'd0,  16'h0000, 16'hFFFF, 1'b0, "R5 read all-ones");
        run_frame(1'b0, 5'd31, 5'd31, 16'h0000, 16'h1234, 1'b0, "R4 write zeros");
        run_frame(1'b0, 5'h15, 5'h0A, 16'h8001, 16'h0000, 1'b1, "R7 write with start poke");
        run_frame(1'b1, 5'h0A, 5'h15, 16'hFFFF, 16'hA5A5, 1'b1, "R7 read with start poke");
        run_frame(1'b1, 5'h01, 5'h10, 16'h0000, 16'h0001, 1'b0, "R5 read lsb only");

        // constrained random frames
        for (int n = 0; n < 10; n++) begin
            run_frame(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom),
                      16'($urandom), 1'($urandom), $sformatf("rand%0d", n));
            repeat ($urandom_range(0, 3)) @(negedge clk);
        end

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule